// File: doc/BRIEF.md
# Request Tracker Occupancy Monitor

This block sits beside a request-tracking queue of `N` entries and gathers the statistics needed to judge how long requests live in it. It follows allocate and release pulses to keep its own count of live entries, and adds that count into a running occupancy integral every cycle. It also counts accepted allocations. The integral divided by the allocation count gives the mean residency of a request in cycles.

From the per-entry valid bits it also counts cycles in which the tracker is completely full and cycles in which it holds anything. A conflict input gives the current depth of a same-address group, which is at most three requests. The monitor counts cycles with a group of two or more, and keeps one group record. When the group is released, that record is classified as 2-way or 3-way by the deepest point it reached.

On request, a sequential restoring divider takes a snapshot of the integral and the allocation count. It produces the average one quotient bit per cycle and raises a done flag when the result is ready. A synchronous clear zeroes all statistics.

Top module: `trk_occ_mon`

## Requirements
- R1: After reset every output is zero.
- R2: The live-entry count `occ_o` rises by one on an allocate pulse and falls by one on a release pulse. It is unchanged when both pulses come in the same cycle. An allocate pulse alone when `occ_o` equals `N` is ignored, and a release pulse alone when `occ_o` is zero is ignored.
- R3: `alloc_cnt_o` rises by one for each accepted allocation, including one paired with a release in the same cycle.
- R4: Each cycle, `occ_sum_o` adds the value `occ_o` held during that cycle. An entry allocated at one edge and released L edges later therefore adds exactly L.
- R5: `full_cyc_o` rises by one for each cycle in which every bit of `valid_i` is set.
- R6: `busy_cyc_o` rises by one for each cycle in which at least one bit of `valid_i` is set.
- R7: `cfl_cyc_o` rises by one for each cycle in which `grp_depth_i` (0 to 3, the number of requests sharing one address) is 2 or more.
- R8: The group record keeps the largest `grp_depth_i` seen since it was last emptied, counting the release cycle itself. On `grp_rel_i`, a maximum of 2 adds one to `grp2_cnt_o` and a maximum of 3 adds one to `grp3_cnt_o`; a smaller maximum adds nothing. The record is then emptied.
- R9: An `avg_req_i` accepted while no division runs snapshots `occ_sum_o` and `alloc_cnt_o` as they stood in that cycle. It drops `avg_done_o`. Exactly `CW` edges after the accepting edge, `avg_done_o` is 1 and `avg_o` is the integer quotient floor(sum / count).
- R10: When the snapshotted allocation count is zero, the result is 0.
- R11: `avg_req_i` is ignored while a division runs, so the running division completes on its original schedule.
- R12: `clr_i` zeroes all counters, the group record, `avg_o` and `avg_done_o`, and aborts a running division. Statistics events and `avg_req_i` in the clear cycle are discarded. `occ_o` still follows that cycle's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all statistics |
| alloc_i | input | 1 | Entry allocate pulse |
| dealloc_i | input | 1 | Entry release pulse |
| valid_i | input | N | Per-entry valid bits of the tracker |
| grp_depth_i | input | 2 | Current size of the same-address group (0 to 3) |
| grp_rel_i | input | 1 | Group record release pulse |
| avg_req_i | input | 1 | Start an average computation |
| occ_o | output | OW | Live entries per the pulse history |
| alloc_cnt_o | output | CW | Accepted allocations |
| occ_sum_o | output | CW | Occupancy integral |
| full_cyc_o | output | CW | Cycles with all entries valid |
| busy_cyc_o | output | CW | Cycles with any entry valid |
| cfl_cyc_o | output | CW | Cycles with a group of two or more |
| grp2_cnt_o | output | CW | Released groups whose peak was 2 |
| grp3_cnt_o | output | CW | Released groups whose peak was 3 |
| avg_o | output | CW | Mean residency in cycles |
| avg_done_o | output | 1 | `avg_o` holds a finished result |

## Verification
The bench fills the tracker and then pushes one more allocate pulse. A design that fails to saturate would wrap the live count and corrupt the integral. It issues simultaneous allocate and release pulses, both on an empty tracker and on a full one. A design that treated them in sequence would lose or gain an entry there, or skip the allocation count.

It re-requests the average on every cycle of a running division. A divider that restarted would raise done late. It clears in the middle of a division, where a divider that was not aborted would raise a stale done. It divides by a zero count, where a restoring divider left unguarded returns all ones.

Group records whose depth peaks and then falls before release would be misclassified by a design that reports the depth at release rather than the peak. A peak reached only in the release cycle would be lost by a design that registers the maximum before classifying it.

// File: rtl/trk_occ_mon.sv
module trk_occ_mon #(
  parameter int N  = 4,
  parameter int CW = 16,
  localparam int OW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          alloc_i,
  input  logic          dealloc_i,
  input  logic [N-1:0]  valid_i,
  input  logic [1:0]    grp_depth_i,
  input  logic          grp_rel_i,
  input  logic          avg_req_i,
  output logic [OW-1:0] occ_o,
  output logic [CW-1:0] alloc_cnt_o,
  output logic [CW-1:0] occ_sum_o,
  output logic [CW-1:0] full_cyc_o,
  output logic [CW-1:0] busy_cyc_o,
  output logic [CW-1:0] cfl_cyc_o,
  output logic [CW-1:0] grp2_cnt_o,
  output logic [CW-1:0] grp3_cnt_o,
  output logic [CW-1:0] avg_o,
  output logic          avg_done_o
);
  localparam int SW = $clog2(CW + 1);
  localparam logic [OW-1:0] NFULL = OW'(N);
  localparam logic [SW-1:0] NSTEP = SW'(CW);

  logic [1:0]    rec_max, peak;
  logic [CW-1:0] dvd, dvs, rem;
  logic [SW-1:0] step;
  logic [CW:0]   trial;
  logic          ge, accept, take;

  assign take   = alloc_i && (dealloc_i || occ_o != NFULL);
  assign peak   = (grp_depth_i > rec_max) ? grp_depth_i : rec_max;
  assign accept = avg_req_i && !clr_i && step == '0;
  assign trial  = {rem, dvd[CW-1]};
  assign ge     = trial >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_o <= '0;
    else if (alloc_i && !dealloc_i && occ_o != NFULL) occ_o <= occ_o + 1'b1;
    else if (dealloc_i && !alloc_i && occ_o != '0) occ_o <= occ_o - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_cnt_o <= '0; occ_sum_o <= '0; full_cyc_o <= '0; busy_cyc_o <= '0;
      cfl_cyc_o <= '0; grp2_cnt_o <= '0; grp3_cnt_o <= '0; rec_max <= '0;
    end else if (clr_i) begin
      alloc_cnt_o <= '0; occ_sum_o <= '0; full_cyc_o <= '0; busy_cyc_o <= '0;
      cfl_cyc_o <= '0; grp2_cnt_o <= '0; grp3_cnt_o <= '0; rec_max <= '0;
    end else begin
      if (take)             alloc_cnt_o <= alloc_cnt_o + 1'b1;
      occ_sum_o <= occ_sum_o + CW'(occ_o);
      if (&valid_i)         full_cyc_o <= full_cyc_o + 1'b1;
      if (|valid_i)         busy_cyc_o <= busy_cyc_o + 1'b1;
      if (grp_depth_i[1])   cfl_cyc_o  <= cfl_cyc_o + 1'b1;
      if (grp_rel_i) begin
        rec_max <= '0;
        if (peak == 2'd2) grp2_cnt_o <= grp2_cnt_o + 1'b1;
        if (peak == 2'd3) grp3_cnt_o <= grp3_cnt_o + 1'b1;
      end else begin
        rec_max <= peak;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd <= '0; dvs <= '0; rem <= '0; step <= '0; avg_o <= '0; avg_done_o <= 1'b0;
    end else if (clr_i) begin
      step <= '0; avg_o <= '0; avg_done_o <= 1'b0;
    end else if (accept) begin
      dvd <= occ_sum_o; dvs <= alloc_cnt_o; rem <= '0;
      step <= NSTEP; avg_done_o <= 1'b0;
    end else if (step != '0) begin
      rem  <= ge ? CW'(trial - {1'b0, dvs}) : trial[CW-1:0];
      dvd  <= {dvd[CW-2:0], ge};
      step <= step - 1'b1;
      if (step == SW'(1)) begin
        avg_done_o <= 1'b1;
        avg_o      <= (dvs == '0) ? '0 : {dvd[CW-2:0], ge};
      end
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) occ_o <= NFULL);
  // R2
  occ_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && dealloc_i) |=> $stable(occ_o));
  // R3
  alloc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && alloc_i && dealloc_i) |=> alloc_cnt_o == $past(alloc_cnt_o) + 1'b1);
  // R4
  sum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> occ_sum_o == $past(occ_sum_o) + CW'($past(occ_o)));
  // R9
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !avg_done_o);
  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (alloc_cnt_o == '0 && occ_sum_o == '0 && !avg_done_o && avg_o == '0));
  // R5
  full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && &valid_i) |=> busy_cyc_o == $past(busy_cyc_o) + 1'b1);
endmodule

// File: tb/trk_occ_mon_tb_top.sv
`timescale 1ns/1ps
module trk_occ_mon_tb_top;
  localparam int N = 4, CW = 16, OW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr_i = 0, alloc_i = 0, dealloc_i = 0;
  logic grp_rel_i = 0, avg_req_i = 0;
  logic [N-1:0] valid_i = '0;
  logic [1:0] grp_depth_i = '0;
  logic [OW-1:0] occ_o;
  logic [CW-1:0] alloc_cnt_o, occ_sum_o, full_cyc_o, busy_cyc_o, cfl_cyc_o;
  logic [CW-1:0] grp2_cnt_o, grp3_cnt_o, avg_o;
  logic avg_done_o;

  always #2.5 clk = ~clk;

  trk_occ_mon #(.N(N), .CW(CW)) dut_i (.*);

  int errors = 0, checks = 0;
  int m_occ = 0, m_step = 0;
  logic [CW-1:0] m_alloc = 0, m_sum = 0, m_full = 0, m_busy = 0, m_cfl = 0;
  logic [CW-1:0] m_g2 = 0, m_g3 = 0, m_avg = 0, m_q = 0;
  logic [1:0] m_rec = 0;
  logic m_done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] quot(logic [CW-1:0] s, logic [CW-1:0] c);
    return (c == 0) ? '0 : s / c;
  endfunction

  task automatic model(logic a, logic d, logic [N-1:0] v, logic [1:0] g, logic rel,
                       logic req, logic c);
    logic acc;
    logic [1:0] pk;
    logic [CW-1:0] s0, a0;
    int o0;
    o0 = m_occ; s0 = m_sum; a0 = m_alloc;
    acc = a && (d || m_occ != N);
    if (a && !d && m_occ != N) m_occ++;
    else if (d && !a && m_occ != 0) m_occ--;
    if (c) begin
      m_alloc = 0; m_sum = 0; m_full = 0; m_busy = 0; m_cfl = 0;
      m_g2 = 0; m_g3 = 0; m_rec = 0; m_step = 0; m_done = 0; m_avg = 0;
    end else begin
      if (acc) m_alloc++;
      m_sum = m_sum + CW'(o0);
      if (&v) m_full++;
      if (|v) m_busy++;
      if (g >= 2) m_cfl++;
      pk = (g > m_rec) ? g : m_rec;
      if (rel) begin
        if (pk == 2) m_g2++;
        if (pk == 3) m_g3++;
        m_rec = 0;
      end else m_rec = pk;
      if (req && m_step == 0) begin
        m_step = CW; m_done = 0; m_q = quot(s0, a0);
      end else if (m_step != 0) begin
        m_step--;
        if (m_step == 0) begin m_done = 1; m_avg = m_q; end
      end
    end
  endtask

  task automatic tick(logic a, logic d, logic [N-1:0] v, logic [1:0] g, logic rel,
                      logic req, logic c);
    alloc_i = a; dealloc_i = d; valid_i = v; grp_depth_i = g; grp_rel_i = rel;
    avg_req_i = req; clr_i = c;
    @(posedge clk);
    model(a, d, v, g, rel, req, c);
    @(negedge clk);
    chk("R2 occ", 32'(occ_o), 32'(m_occ));
    chk("R3 alloc", 32'(alloc_cnt_o), 32'(m_alloc));
    chk("R4 sum", 32'(occ_sum_o), 32'(m_sum));
    chk("R5 full", 32'(full_cyc_o), 32'(m_full));
    chk("R6 busy", 32'(busy_cyc_o), 32'(m_busy));
    chk("R7 cfl", 32'(cfl_cyc_o), 32'(m_cfl));
    chk("R8 grp2", 32'(grp2_cnt_o), 32'(m_g2));
    chk("R8 grp3", 32'(grp3_cnt_o), 32'(m_g3));
    chk("R9 avg", 32'(avg_o), 32'(m_avg));
    chk("R9 done", 32'(avg_done_o), 32'(m_done));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 occ", 32'(occ_o), 0);
    chk("R1 avg", 32'(avg_o), 0);
    chk("R1 done", 32'(avg_done_o), 0);
    chk("R1 sum", 32'(occ_sum_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: division with a zero count
    tick(0, 0, '0, 0, 0, 1, 0);
    idle(CW);
    chk("R10 zero count", 32'(avg_o), 0);
    chk("R10 done", 32'(avg_done_o), 1);
    // R2: fill past N, pair at full, drain past zero
    for (int i = 0; i < N + 2; i++) tick(1, 0, '1, 0, 0, 0, 0);
    tick(1, 1, '1, 0, 0, 0, 0);
    for (int i = 0; i < N + 2; i++) tick(0, 1, '0, 0, 0, 0, 0);
    tick(1, 1, '0, 0, 0, 0, 0);
    chk("R2 empty pair", 32'(occ_o), 0);
    // R8: peak then fall, peak in release cycle
    tick(0, 0, '0, 3, 0, 0, 0);
    tick(0, 0, '0, 1, 1, 0, 0);
    tick(0, 0, '0, 2, 1, 0, 0);
    tick(0, 0, '0, 1, 0, 0, 0);
    tick(0, 0, '0, 3, 1, 0, 0);
    // R11: request on every cycle of a division
    tick(1, 0, '0, 0, 0, 1, 0);
    for (int i = 0; i < CW - 1; i++) tick(0, 0, '0, 0, 0, 1, 0);
    chk("R11 not yet", 32'(avg_done_o), 0);
    tick(0, 0, '0, 0, 0, 1, 0);
    chk("R11 on time", 32'(avg_done_o), 1);
    idle(CW + 1);
    // R12: clear during a division
    tick(0, 0, '0, 0, 0, 1, 0);
    idle(3);
    tick(1, 0, '1, 3, 1, 1, 1);
    chk("R12 cleared", 32'(alloc_cnt_o), 0);
    idle(CW + 2);
    chk("R12 no stale done", 32'(avg_done_o), 0);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [N-1:0] v;
      v = ($urandom % 4 == 0) ? '1 : N'($urandom);
      tick(($urandom % 3) == 0, ($urandom % 3) == 0, v, 2'($urandom),
           ($urandom % 6) == 0, ($urandom % 10) == 0, ($urandom % 400) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule